// File: doc/BRIEF.md
# Power-Down and Calibration Sequencer

This block sequences a clock-recovery front end from a single control pin that does two jobs. While the pin is high, the core is held in power-down, its high-speed outputs are parked and its reset is held. When the pin falls, the falling edge is a calibration request. The request only counts if two things are true: the pin was high long enough, and a reference clock is reported valid. If both hold, the sequencer pulses a calibration start and waits for the calibration engine to report completion. It then opens an acquisition window of fixed length and finally hands over to normal tracking.

A falling edge that comes too early, or that arrives without a reference clock, takes the block straight to tracking without calibrating, and a sticky flag records that. A calibration that never completes ends after a timeout, and a sticky error flag records it. Throughout power-down, calibration and acquisition, a mask output tells the lock detector to keep its loss indication deasserted.

The pin is asynchronous and passes through a synchroniser. The reference-valid and calibration-done inputs are synchronous to the system clock.

Top module: `pdcal_sequencer`

## Requirements
- R1: After reset the block is in power-down: outEnable=0, coreReset=1, lockIndMask=1, busy=1, calStart=0, acquiring=0, calSkipped=0, calError=0. It stays there as long as no high-to-low transition of pdCalIn is seen, even if pdCalIn is low.
- R2: pdCalIn is synchronised through SYNC_STAGES flops. From any state, a high level on pdCalIn sampled at clock edge k puts the block in power-down at edge k+SYNC_STAGES: outEnable=0, coreReset=1, lockIndMask=1.
- R3: A qualified falling edge raises calStart at the third clock edge after the first edge that samples pdCalIn low (with SYNC_STAGES=2). Qualified means pdCalIn was sampled high on at least HIGH_MIN_CYCLES consecutive edges before that, and refClkValid=1 when the synchronised edge is seen.
- R4: calStart is high for exactly one cycle. coreReset is high in that cycle and low while the block waits for completion. outEnable is 0 during both.
- R5: When calDone=1 while the block waits for completion, acquiring rises at the next edge and stays high for exactly ACQ_CYCLES cycles, with outEnable=1, busy=1 and lockIndMask=1. After that the block tracks: busy=0, lockIndMask=0, outEnable=1.
- R6: A falling edge after fewer than HIGH_MIN_CYCLES high samples goes straight to tracking, at the edge where a qualified one would raise calStart. No calStart is produced, and calSkipped is set.
- R7: A falling edge with refClkValid=0 behaves as in R6: tracking, no calStart, and calSkipped set.
- R8: If calDone does not arrive within CAL_TIMEOUT_CYCLES cycles of waiting, the block goes to tracking without an acquisition window and sets calError.
- R9: calDone has no effect outside the completion wait. In tracking, busy and acquiring stay 0 while it is high.
- R10: calSkipped and calError are sticky. They stay set through later calibrations and clear only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdCalIn | input | 1 | Asynchronous control pin: high level = power-down, falling edge = calibrate |
| refClkValid | input | 1 | Reference clock present, synchronous |
| calDone | input | 1 | Calibration engine finished |
| outEnable | output | 1 | High-speed output enable |
| coreReset | output | 1 | Core reset, active high |
| calStart | output | 1 | One-cycle calibration start pulse |
| busy | output | 1 | Not yet tracking |
| acquiring | output | 1 | Acquisition window open |
| lockIndMask | output | 1 | Forces the loss-of-lock indication deasserted |
| calSkipped | output | 1 | Sticky: a falling edge was not qualified |
| calError | output | 1 | Sticky: calibration timed out |

## Verification
The bench builds the block with HIGH_MIN_CYCLES=8, CAL_TIMEOUT_CYCLES=20 and ACQ_CYCLES=12 in place of the microsecond and millisecond defaults. With these values, the qualification boundary (7 versus 8 high samples), the full timeout path and the exact length of the acquisition window can each be counted cycle by cycle within a few dozen clocks. The default of two synchroniser stages is kept, so the latencies stated in R2 and R3 are the ones the bench measures.

// File: rtl/pdcal_pkg.sv
package pdcal_pkg;

  typedef enum logic [2:0] {
    ST_POWER_DOWN = 3'd0,
    ST_CAL_START  = 3'd1,
    ST_CAL_WAIT   = 3'd2,
    ST_ACQUIRE    = 3'd3,
    ST_TRACK      = 3'd4
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic timerClr;
    logic timerRun;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic pdLevel;
    logic fallEdge;
    logic highOk;
    logic calTimeout;
    logic acqDone;
  } dpStatus_t;

endpackage

// File: rtl/pdcal_datapath.sv
module pdcal_datapath
  import pdcal_pkg::*;
#(
  parameter int SYNC_STAGES        = 2,
  parameter int HIGH_MIN_CYCLES    = 50,
  parameter int CAL_TIMEOUT_CYCLES = 50000,
  parameter int ACQ_CYCLES         = 75000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pdCalAsync,
  input  dpStrobe_t strobe,
  output dpStatus_t status
);

  localparam int HW          = $clog2(HIGH_MIN_CYCLES + 1);
  localparam int TIMER_LIMIT = (CAL_TIMEOUT_CYCLES > ACQ_CYCLES) ? CAL_TIMEOUT_CYCLES : ACQ_CYCLES;
  localparam int TW          = $clog2(TIMER_LIMIT + 1);
  localparam logic [HW-1:0] HIGH_MIN  = HW'(HIGH_MIN_CYCLES);
  localparam logic [TW-1:0] CAL_LAST  = TW'(CAL_TIMEOUT_CYCLES - 1);
  localparam logic [TW-1:0] ACQ_LAST  = TW'(ACQ_CYCLES - 1);
  localparam logic [TW-1:0] TIMER_TOP = TW'(TIMER_LIMIT);

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   pdLevel;
  logic                   pdPrev;
  logic [HW-1:0]          highCount;
  logic [TW-1:0]          timerCount;

  // synchroniser: depth chosen by parameter
  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], pdCalAsync};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= pdCalAsync;
      end
    end
  endgenerate

  assign pdLevel = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdPrev <= 1'b0;
    else       pdPrev <= pdLevel;
  end

  // high-time counter, saturating at the qualification threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  highCount <= '0;
    else if (!pdLevel)          highCount <= '0;
    else if (highCount != HIGH_MIN) highCount <= highCount + 1'b1;
  end

  // shared window timer for completion wait and acquisition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timerCount <= '0;
    else if (strobe.timerClr)  timerCount <= '0;
    else if (strobe.timerRun && timerCount != TIMER_TOP) timerCount <= timerCount + 1'b1;
  end

  always_comb begin
    status.pdLevel    = pdLevel;
    status.fallEdge   = pdPrev & ~pdLevel;
    status.highOk     = (highCount == HIGH_MIN);
    status.calTimeout = (timerCount == CAL_LAST);
    status.acqDone    = (timerCount == ACQ_LAST);
  end

  // R2: synchronised level equals the pin sampled SYNC_STAGES edges earlier
  assert_sync_depth_R2 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdLevel) |-> $past(pdCalAsync, SYNC_STAGES))
    else $error("synchroniser depth mismatch");

endmodule

// File: rtl/pdcal_control.sv
module pdcal_control
  import pdcal_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStatus_t status,
  input  logic      refClkValid,
  input  logic      calDone,
  output dpStrobe_t strobe,
  output logic      outEnable,
  output logic      coreReset,
  output logic      calStart,
  output logic      busy,
  output logic      acquiring,
  output logic      lockIndMask,
  output logic      calSkipped,
  output logic      calError
);

  seqState_t stateQ, stateD;
  logic      setSkip, setErr;

  always_comb begin
    stateD  = stateQ;
    setSkip = 1'b0;
    setErr  = 1'b0;
    if (status.pdLevel) begin
      stateD = ST_POWER_DOWN;
    end else begin
      unique case (stateQ)
        ST_POWER_DOWN: begin
          if (status.fallEdge) begin
            if (status.highOk && refClkValid) begin
              stateD = ST_CAL_START;
            end else begin
              stateD  = ST_TRACK;
              setSkip = 1'b1;
            end
          end
        end
        ST_CAL_START: stateD = ST_CAL_WAIT;
        ST_CAL_WAIT: begin
          if (calDone) begin
            stateD = ST_ACQUIRE;
          end else if (status.calTimeout) begin
            stateD = ST_TRACK;
            setErr = 1'b1;
          end
        end
        ST_ACQUIRE: if (status.acqDone) stateD = ST_TRACK;
        ST_TRACK:   stateD = ST_TRACK;
        default:    stateD = ST_POWER_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_POWER_DOWN;
      calSkipped <= 1'b0;
      calError   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (setSkip) calSkipped <= 1'b1;
      if (setErr)  calError   <= 1'b1;
    end
  end

  always_comb begin
    strobe.timerClr = (stateQ != stateD);
    strobe.timerRun = (stateQ == ST_CAL_WAIT) || (stateQ == ST_ACQUIRE);
    outEnable   = (stateQ == ST_ACQUIRE) || (stateQ == ST_TRACK);
    coreReset   = (stateQ == ST_POWER_DOWN) || (stateQ == ST_CAL_START);
    calStart    = (stateQ == ST_CAL_START);
    acquiring   = (stateQ == ST_ACQUIRE);
    busy        = (stateQ != ST_TRACK);
    lockIndMask = (stateQ != ST_TRACK);
  end

  assert_park_on_high_R2 : assert property (@(posedge clk) disable iff (!rstN)
    status.pdLevel |=> (!outEnable && coreReset && lockIndMask))
    else $error("outputs not parked while pin high");

  assert_single_pulse_R4 : assert property (@(posedge clk) disable iff (!rstN)
    calStart |=> !calStart)
    else $error("calibration start longer than one cycle");

  assert_ref_needed_R7 : assert property (@(posedge clk) disable iff (!rstN)
    calStart |-> ($past(refClkValid) && $past(status.highOk)))
    else $error("calibration started without qualification");

  assert_done_to_acq_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CAL_WAIT && calDone && !status.pdLevel) |=> acquiring)
    else $error("completion did not open acquisition");

  assert_skip_sticky_R10 : assert property (@(posedge clk) disable iff (!rstN)
    calSkipped |=> calSkipped)
    else $error("skip flag cleared");

  assert_err_sticky_R10 : assert property (@(posedge clk) disable iff (!rstN)
    calError |=> calError)
    else $error("error flag cleared");

  assert_skip_tracks_R6 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(calSkipped) |-> (stateQ == ST_TRACK))
    else $error("skip without tracking");

endmodule

// File: rtl/pdcal_sequencer.sv
module pdcal_sequencer
  import pdcal_pkg::*;
#(
  parameter int SYNC_STAGES        = 2,
  parameter int HIGH_MIN_CYCLES    = 50,
  parameter int CAL_TIMEOUT_CYCLES = 50000,
  parameter int ACQ_CYCLES         = 75000
) (
  input  logic clk,
  input  logic rstN,
  input  logic pdCalIn,
  input  logic refClkValid,
  input  logic calDone,
  output logic outEnable,
  output logic coreReset,
  output logic calStart,
  output logic busy,
  output logic acquiring,
  output logic lockIndMask,
  output logic calSkipped,
  output logic calError
);

  dpStrobe_t strobe;
  dpStatus_t status;

  pdcal_datapath #(
    .SYNC_STAGES       (SYNC_STAGES),
    .HIGH_MIN_CYCLES   (HIGH_MIN_CYCLES),
    .CAL_TIMEOUT_CYCLES(CAL_TIMEOUT_CYCLES),
    .ACQ_CYCLES        (ACQ_CYCLES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .pdCalAsync(pdCalIn),
    .strobe    (strobe),
    .status    (status)
  );

  pdcal_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .status     (status),
    .refClkValid(refClkValid),
    .calDone    (calDone),
    .strobe     (strobe),
    .outEnable  (outEnable),
    .coreReset  (coreReset),
    .calStart   (calStart),
    .busy       (busy),
    .acquiring  (acquiring),
    .lockIndMask(lockIndMask),
    .calSkipped (calSkipped),
    .calError   (calError)
  );

endmodule

// File: tb/pdcal_sequencer_bench.sv
module pdcal_sequencer_bench;

  localparam int HMIN = 8;
  localparam int CTO  = 20;
  localparam int ACQ  = 12;

  logic clk = 1'b0;
  logic rstN, pdCalIn, refClkValid, calDone;
  logic outEnable, coreReset, calStart, busy, acquiring, lockIndMask, calSkipped, calError;

  int checks = 0;
  int errors = 0;

  int calCnt, acqCnt, trackIdx, calIdx;
  logic csRst, cwRst, cwOe;

  always #10 clk = ~clk;  // 50 MHz

  pdcal_sequencer #(
    .SYNC_STAGES(2), .HIGH_MIN_CYCLES(HMIN), .CAL_TIMEOUT_CYCLES(CTO), .ACQ_CYCLES(ACQ)
  ) u_pdcal_sequencer (
    .clk(clk), .rstN(rstN), .pdCalIn(pdCalIn), .refClkValid(refClkValid), .calDone(calDone),
    .outEnable(outEnable), .coreReset(coreReset), .calStart(calStart), .busy(busy),
    .acquiring(acquiring), .lockIndMask(lockIndMask), .calSkipped(calSkipped), .calError(calError)
  );

  typedef struct packed {
    logic [7:0] hold;
    logic       refOk;
    logic [7:0] doneAfter;  // 0 = never
    logic       expCal;
    logic       expErr;
    logic       expSkip;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{8'd8,  1'b1, 8'd3, 1'b1, 1'b0, 1'b0},  // exact threshold
    '{8'd7,  1'b1, 8'd3, 1'b0, 1'b0, 1'b1},  // one short
    '{8'd30, 1'b0, 8'd3, 1'b0, 1'b0, 1'b1},  // no reference
    '{8'd12, 1'b1, 8'd0, 1'b1, 1'b1, 1'b0},  // timeout
    '{8'd20, 1'b1, 8'd1, 1'b1, 1'b0, 1'b0},  // immediate completion
    '{8'd1,  1'b1, 8'd2, 1'b0, 1'b0, 1'b1}   // glitch
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyReset(input logic refOk);
    rstN = 1'b0; pdCalIn = 1'b1; calDone = 1'b0; refClkValid = refOk;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runFall(input int hold, input int doneAfter);
    pdCalIn = 1'b1;
    repeat (hold) @(posedge clk);
    @(negedge clk);
    pdCalIn = 1'b0;
    calCnt = 0; acqCnt = 0; trackIdx = 0; calIdx = 0;
    csRst = 1'b0; cwRst = 1'b1; cwOe = 1'b1;
    for (int idx = 1; idx <= 400; idx++) begin
      @(negedge clk);
      if (calStart) begin calCnt++; if (calIdx == 0) calIdx = idx; end
      if (idx == 3) csRst = coreReset;
      if (idx == 4) begin cwRst = coreReset; cwOe = outEnable; end
      if (acquiring) begin acqCnt++; calDone = 1'b0; end
      if (!busy) begin trackIdx = idx; break; end
      if (doneAfter != 0 && calIdx != 0 && idx == calIdx + doneAfter) calDone = 1'b1;
    end
    calDone = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, pin low, no edge
    applyReset(1'b1);
    pdCalIn = 1'b0;
    @(negedge clk);
    check("R1 outEnable", outEnable, 0);
    check("R1 coreReset/mask/busy", {coreReset, lockIndMask, busy}, 3'b111);
    check("R1 calStart/acquiring/flags", {calStart, acquiring, calSkipped, calError}, 0);
    repeat (20) @(negedge clk);
    check("R1 still parked with pin low", {busy, outEnable}, 2'b10);

    // table walk
    for (int v = 0; v < 6; v++) begin
      int expTrack;
      string rq;
      applyReset(VECS[v].refOk);
      runFall(int'(VECS[v].hold), int'(VECS[v].doneAfter));
      rq = VECS[v].expCal ? "R3" : (VECS[v].refOk ? "R6" : "R7");
      if (!VECS[v].expCal)        expTrack = 3;
      else if (VECS[v].doneAfter == 0) expTrack = 4 + CTO;
      else                        expTrack = 4 + int'(VECS[v].doneAfter) + ACQ;
      check({rq, " calStart count"}, calCnt, int'(VECS[v].expCal));
      check({VECS[v].expErr ? "R8" : (VECS[v].expCal ? "R5" : rq), " track cycle"}, trackIdx, expTrack);
      check("R5 acquisition length", acqCnt,
            (VECS[v].expCal && VECS[v].doneAfter != 0) ? ACQ : 0);
      check("R8 calError", calError, int'(VECS[v].expErr));
      check({rq, " calSkipped"}, calSkipped, int'(VECS[v].expSkip));
      check("R5 tracking outputs", {outEnable, lockIndMask}, 2'b10);
      if (VECS[v].expCal) begin
        check("R3 calStart latency", calIdx, 3);
        check("R4 coreReset in start", csRst, 1);
        check("R4 wait coreReset/outEnable", {cwRst, cwOe}, 0);
      end
    end

    // R9 then R2: calDone while tracking, then pin high
    applyReset(1'b1);
    runFall(HMIN, 2);
    calDone = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R9 calDone ignored in tracking", {busy, acquiring}, 0);
    end
    calDone = 1'b0;
    pdCalIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 still enabled before latency", outEnable, 1);
    @(negedge clk);
    check("R2 parked after latency", {outEnable, coreReset, lockIndMask}, 3'b011);

    // R10: skip flag survives a later good calibration
    applyReset(1'b0);
    runFall(10, 0);
    check("R7 skipped without ref", calSkipped, 1);
    refClkValid = 1'b1;
    runFall(10, 2);
    check("R3 later calibration runs", calCnt, 1);
    check("R10 calSkipped sticky", calSkipped, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule